// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

This block watches a bank of general-purpose input pins and turns pin activity into interrupt requests. Each pin is first brought into the local clock domain through a two-stage synchronizer. The synchronized value then feeds an edge detector and a level detector side by side. A per-pin type bit picks which of the two drives a sticky status bit. A polarity bit chooses rising/high or falling/low, and an any-edge bit makes the edge detector respond to both directions.

Status bits stay set for as long as their selected condition holds. Software clears them by writing ones to the acknowledge register. An acknowledge only takes effect on a bit whose condition is absent in that cycle, so a level source that is still active re-latches at once. A per-pin mask gates status onto the single combined interrupt output. Detection and latching carry on while a pin is masked, so an event that arrives while masked raises the output as soon as the pin is unmasked. Configuration is written through a plain write strobe with a register select. The status vector is readable at all times.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all status bits are 0, every pin is masked, every pin is in level mode (type 0) with high polarity (polarity 1), and any-edge is off.
- R2: A pin change reaches detection through two synchronizer flops. A level-high change applied before clock edge k sets status on edge k+2, and not before.
- R3: In level mode (type bit 0), a pin's condition is true whenever its synchronized value equals its polarity bit (1 = high, 0 = low).
- R4: In edge mode (type bit 1) with any-edge off, polarity 1 detects a 0-to-1 change of the synchronized value and polarity 0 detects a 1-to-0 change. The opposite change sets nothing.
- R5: In edge mode with the any-edge bit set, both directions of change set status, whatever the polarity.
- R6: A status bit set by an edge stays set after the pin returns, until it is acknowledged.
- R7: A write to the acknowledge select clears each status bit written as 1 whose condition is absent that cycle. Bits written as 0 are unaffected.
- R8: An acknowledge of a level-mode bit whose level is still present leaves the bit set.
- R9: When a condition and an acknowledge of the same bit coincide in one cycle, the bit ends up set.
- R10: The interrupt output is the OR over all pins of status AND NOT mask. A masked pin still latches status, and the output rises in the cycle after the unmasking write.
- R11: Register selects are: 0 type, 1 polarity, 2 any-edge, 3 mask (1 = masked), 4 acknowledge (write-one-to-clear). A write takes effect at the next clock edge. Selects 5 to 7, and cycles with the write strobe low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPIN | Raw asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | NPIN | Write data, one bit per pin |
| status_o | output | NPIN | Latched interrupt status per pin |
| irq_o | output | 1 | Combined, masked interrupt request |

## Verification
A wrong synchronizer depth or a stale previous sample shows as status rising one cycle early or late relative to the pin change, or as an edge seen in the wrong direction. The bench compares every cycle, so such an error appears on the first pin transition. A corrupted configuration or status bit shows on status_o in the cycle after the faulty write or acknowledge. A mask error shows on irq_o in that same cycle. Priority mistakes between set and acknowledge show as a bit that stays clear after a coinciding edge, or as a level bit that drops while its level is still held.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TYPE = 3'd0,
    SEL_POL  = 3'd1,
    SEL_ANY  = 3'd2,
    SEL_MASK = 3'd3,
    SEL_ACK  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] raw_i,
  output logic [NPIN-1:0] sync_o
);
  logic [NPIN-1:0] meta_q;
  logic [NPIN-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) |=> (sync_o == $past(raw_i, 2))));
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NPIN-1:0]  wr_data,
  output logic [NPIN-1:0]  type_o,
  output logic [NPIN-1:0]  pol_o,
  output logic [NPIN-1:0]  any_o,
  output logic [NPIN-1:0]  mask_o,
  output logic [NPIN-1:0]  ack_o
);
  reg_sel_e        sel;
  logic [NPIN-1:0] type_q, pol_q, any_q, mask_q;
  logic            wr_mask;

  assign sel     = reg_sel_e'(wr_sel);
  assign wr_mask = wr_en && (sel == SEL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      pol_q  <= '1;
      any_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (sel)
        SEL_TYPE: type_q <= wr_data;
        SEL_POL:  pol_q  <= wr_data;
        SEL_ANY:  any_q  <= wr_data;
        SEL_MASK: mask_q <= wr_data;
        default:  ;
      endcase
    end
  end

  assign ack_o  = (wr_en && sel == SEL_ACK) ? wr_data : '0;
  assign type_o = type_q;
  assign pol_o  = pol_q;
  assign any_o  = any_q;
  assign mask_o = mask_q;

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask |=> $stable(mask_o)));
  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask |=> (mask_o == $past(wr_data))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] type_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] any_i,
  input  logic [NPIN-1:0] ack_i,
  output logic [NPIN-1:0] set_o,
  output logic [NPIN-1:0] status_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] status_q;
  logic [NPIN-1:0] edge_hit;
  logic [NPIN-1:0] level_hit;

  function automatic logic edge_event(input logic cur, input logic old,
                                      input logic pol, input logic any);
    logic up, down;
    up   = cur & ~old;
    down = ~cur & old;
    if (any) return up | down;
    return pol ? up : down;
  endfunction

  function automatic logic level_event(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign edge_hit[i]  = edge_event(sync_i[i], prev_q[i], pol_i[i], any_i[i]);
    assign level_hit[i] = level_event(sync_i[i], pol_i[i]);
    assign set_o[i]     = type_i[i] ? edge_hit[i] : level_hit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      status_q <= set_o | (status_q & ~ack_i);
    end
  end

  assign status_o = status_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (1'b1 |=> ((status_o & $past(set_o)) == $past(set_o))));
  // R7
  clear_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (1'b1 |=> ((~status_o & $past(status_o) & ~$past(ack_i)) == '0)));
  // R6
  rise_by_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_o)) == '0)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_in,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NPIN-1:0]  wr_data,
  output logic [NPIN-1:0]  status_o,
  output logic             irq_o
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] cfg_type, cfg_pol, cfg_any, cfg_mask, ack_vec;
  logic [NPIN-1:0] set_vec;
  logic [NPIN-1:0] live;

  gpio_irq_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(pin_sync)
  );

  gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .type_o(cfg_type), .pol_o(cfg_pol),
    .any_o(cfg_any), .mask_o(cfg_mask), .ack_o(ack_vec)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .type_i(cfg_type),
    .pol_i(cfg_pol), .any_i(cfg_any), .ack_i(ack_vec),
    .set_o(set_vec), .status_o(status_o)
  );

  assign live  = status_o & ~cfg_mask;
  assign irq_o = |live;

  // R10
  masked_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & cfg_mask) != '0 |=> (status_o & $past(set_vec & cfg_mask)) != '0));
  // R10
  unmask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(|(status_o & cfg_mask)) && $stable(status_o) |-> irq_o));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int NPIN = 32;
  localparam time CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin_in = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_sel = '0;
  logic [NPIN-1:0] wr_data = '0;
  logic [NPIN-1:0] status_o;
  logic            irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [NPIN-1:0] m_a, m_b, m_old, m_st, m_typ, m_pol, m_any, m_msk;

  gpio_irq_bank #(.NPIN(NPIN)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .status_o(status_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NPIN-1:0] want_cond();
    logic [NPIN-1:0] r;
    for (int i = 0; i < NPIN; i++) begin
      if (m_typ[i]) begin
        if (m_a[i] === m_old[i]) r[i] = 1'b0;
        else if (m_any[i]) r[i] = 1'b1;
        else r[i] = (m_a[i] == m_pol[i]);
      end else begin
        r[i] = (m_a[i] == m_pol[i]);
      end
    end
    return r;
  endfunction

  function automatic logic want_irq();
    for (int i = 0; i < NPIN; i++)
      if (m_st[i] && !m_msk[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    m_a = '0; m_b = '0; m_old = '0; m_st = '0;
    m_typ = '0; m_pol = '1; m_any = '0; m_msk = '1;
  endtask

  task automatic model_step();
    logic [NPIN-1:0] c, ak;
    c  = want_cond();
    ak = (wr_en && wr_sel == 3'd4) ? wr_data : '0;
    for (int i = 0; i < NPIN; i++)
      m_st[i] = c[i] ? 1'b1 : (ak[i] ? 1'b0 : m_st[i]);
    m_old = m_a; m_a = m_b; m_b = pin_in;
    if (wr_en) begin
      if (wr_sel == 3'd0) m_typ = wr_data;
      if (wr_sel == 3'd1) m_pol = wr_data;
      if (wr_sel == 3'd2) m_any = wr_data;
      if (wr_sel == 3'd3) m_msk = wr_data;
    end
  endtask

  task automatic chk(input string tag, input logic [NPIN-1:0] act,
                     input logic [NPIN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven, advance, compare at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R10 status model", status_o, m_st);
    chk("R10 irq model", {{(NPIN-1){1'b0}}, irq_o}, {{(NPIN-1){1'b0}}, want_irq()});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [NPIN-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", status_o, '0);
    chk("R1 irq", {31'd0, irq_o}, '0);
    // R1 masked at reset: level-high event latches, irq stays low
    pin_in[0] = 1'b1;
    ticks(3);
    chk("R1 masked latch", status_o, 32'h1);
    chk("R1 irq masked", {31'd0, irq_o}, '0);
    pin_in[0] = 1'b0;
    ticks(2);
    wr(3'd4, 32'h1);
    wr(3'd3, '0);
    // R2 two-flop delay
    pin_in[1] = 1'b1;
    ticks(2);
    chk("R2 not yet", status_o & 32'h2, '0);
    tick();
    chk("R2 set on third edge", status_o & 32'h2, 32'h2);
    chk("R3 level high irq", {31'd0, irq_o}, 32'h1);
    // R8 ack while level held
    wr(3'd4, 32'h2);
    chk("R8 held level keeps status", status_o & 32'h2, 32'h2);
    pin_in[1] = 1'b0;
    ticks(3);
    chk("R8 status stays until ack", status_o & 32'h2, 32'h2);
    wr(3'd4, 32'h2);
    chk("R7 ack after level gone", status_o & 32'h2, '0);
    // R4 rising edge on pin 2
    wr(3'd0, 32'h4);
    pin_in[2] = 1'b1;
    ticks(3);
    chk("R4 rising", status_o & 32'h4, 32'h4);
    pin_in[2] = 1'b0;
    ticks(3);
    chk("R6 sticky after return", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h0);
    chk("R7 zero bits no effect", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h4);
    chk("R7 edge ack clears", status_o & 32'h4, '0);
    // R4 falling polarity
    wr(3'd1, ~32'h4);
    pin_in[2] = 1'b1;
    ticks(3);
    chk("R4 falling ignores rise", status_o & 32'h4, '0);
    pin_in[2] = 1'b0;
    ticks(3);
    chk("R4 falling detected", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h4);
    // R5 any edge
    wr(3'd2, 32'h4);
    pin_in[2] = 1'b1;
    ticks(3);
    chk("R5 rise with any", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h4);
    pin_in[2] = 1'b0;
    ticks(3);
    chk("R5 fall with any", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h4);
    chk("R5 cleared", status_o & 32'h4, '0);
    // R9 set and ack in the same cycle
    pin_in[2] = 1'b1;
    ticks(2);
    wr(3'd4, 32'h4);
    chk("R9 set wins", status_o & 32'h4, 32'h4);
    wr(3'd4, 32'h4);
    chk("R9 later ack clears", status_o & 32'h4, '0);
    // R10 mask blocks only propagation
    wr(3'd3, 32'h8);
    pin_in[3] = 1'b1;
    ticks(3);
    chk("R10 masked latch", status_o & 32'h8, 32'h8);
    chk("R10 irq low while masked", {31'd0, irq_o}, '0);
    wr(3'd3, '0);
    chk("R10 irq after unmask", {31'd0, irq_o}, 32'h1);
    // R11 idle and unused selects change nothing
    wr_en = 1'b0; wr_sel = 3'd4; wr_data = 32'h8;
    tick();
    pin_in[3] = 1'b0;
    ticks(3);
    chk("R11 strobe low no ack", status_o & 32'h8, 32'h8);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R11 unused select no change", status_o & 32'h8, 32'h8);
    chk("R11 mask kept", {31'd0, irq_o}, 32'h1);
    wr(3'd4, 32'h8);
    // R3 level low
    wr(3'd1, ~32'h10);
    ticks(1);
    chk("R3 level low sets", status_o & 32'h10, 32'h10);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      pin_in = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1; wr_sel = 3'($urandom_range(0, 7)); wr_data = $urandom;
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule